// File: doc/BRIEF.md
# General-Purpose Event Status/Enable Block with Hotplug SCI

This block holds a set of general-purpose event status bytes and a matching set of enable bytes behind a byte-wide register port. Hardware event pulses set status bits. Software clears them by writing ones. The enable bytes are ordinary read/write storage. One event bit is the hotplug bit: byte 0, bit 3. It drives a level-sensitive system control interrupt line, `sci_line`. A separate flag, `sci_mark`, records that the interrupt was raised.

The two ways software can lower the interrupt behave differently. Clearing the hotplug status bit drops the line but leaves the mark set. Disabling the hotplug enable bit drops the line and also clears the mark. The block is placed between the event sources and an interrupt controller. A register port of the host decodes the block's byte offsets and drives them as `io_addr`.

Top module: `gpe_event_block`

## Requirements
- R1: With N = `NUM_STS_BYTES` (default 2), status byte k sits at offset k and enable byte k sits at offset N+k. At the default, offsets 0 and 1 are status and offsets 2 and 3 are enable. `io_rdata` combinationally returns the byte addressed by `io_addr`.
- R2: A write (`io_sel`=1, `io_wr`=1) to a status offset clears every status bit whose write-data bit is 1 and leaves bits written as 0 unchanged, from the next clock edge.
- R3: A write to an enable offset replaces that whole enable byte from the next clock edge, and the new value reads back.
- R4: `evt_set` bit 8*k+b sets status byte k bit b at the next edge, and the bit stays set until cleared. If a set and a write-one-to-clear hit the same bit in one cycle, the bit ends up set.
- R5: A hotplug event (`evt_set` bit 3) while enable byte 0 bit 3 is 1 drives `sci_line` and `sci_mark` to 1 at the next edge. With that enable bit at 0, the status bit is set but neither output changes. `sci_line` is never 1 while `sci_mark` is 0.
- R6: While `sci_mark` is 1, a status write that takes status byte 0 bit 3 from 1 to 0 drives `sci_line` to 0 at the next edge and leaves `sci_mark` at 1.
- R7: While `sci_mark` is 1, a write to enable byte 0 with data bit 3 at 0 drives both `sci_line` and `sci_mark` to 0 at the next edge. The status bits are not changed.
- R8: Writes to any other byte, status writes that do not clear bit 3, and enable writes to byte 0 with bit 3 at 1 leave `sci_line` and `sci_mark` unchanged.
- R9: After reset, all status bytes, all enable bytes, `sci_line` and `sci_mark` are 0.
- R10: A hotplug event that meets an enable bit 3 already at 1 raises the interrupt even if a lowering write (R6 or R7) lands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 1 | Register access strobe |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | $clog2(2*NUM_STS_BYTES) | Byte offset within the block |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr` |
| evt_set | input | 8*NUM_STS_BYTES | One-cycle event pulses, one per status bit |
| sci_line | output | 1 | Level interrupt for the hotplug event |
| sci_mark | output | 1 | Records that the interrupt was raised |

## Verification
The status bytes are driven with mixed event patterns that exclude bit 3. Partial, zero and full clear masks are then written to them. This separates write-one-to-clear from plain overwrite and shows that ordinary events leave the interrupt alone. The hotplug bit is exercised with the enable bit off and on. The interrupt is then lowered once through the status path and once through the enable path, and the mark is read after each. This tells the two lowering rules apart. Writes to neighbouring bytes and same-cycle event/clear collisions show that the interrupt depends on bit 3 of byte 0 alone and that the event takes priority.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] gbyte_t;
   typedef enum logic [1:0] {
      SCI_HOLD      = 2'd0,
      SCI_RAISE     = 2'd1,
      SCI_DROP_LINE = 2'd2,
      SCI_DROP_ALL  = 2'd3
   } sci_act_e;
endpackage

// File: rtl/gpe_addr_dec.sv
module gpe_addr_dec #(
   parameter int NUM_STS_BYTES = 2,
   parameter int AW = 2
) (
   input  logic                     io_sel,
   input  logic                     io_wr,
   input  logic [AW-1:0]            io_addr,
   output logic [NUM_STS_BYTES-1:0] sts_we,
   output logic [NUM_STS_BYTES-1:0] en_we
);
   logic wr_cyc;
   assign wr_cyc = io_sel & io_wr;

   for (genvar i = 0; i < NUM_STS_BYTES; i++) begin : g_dec
      assign sts_we[i] = wr_cyc & (io_addr == AW'(i));
      assign en_we[i]  = wr_cyc & (io_addr == AW'(NUM_STS_BYTES + i));
   end
endmodule

// File: rtl/gpe_sts_byte.sv
module gpe_sts_byte
   import gpe_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   clr_we,
   input  gbyte_t clr_mask,
   input  gbyte_t set_mask,
   output gbyte_t q
);
   gbyte_t clr_eff;
   assign clr_eff = clr_we ? clr_mask : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr_eff) | set_mask;
   end
endmodule

// File: rtl/gpe_sci_ctrl.sv
module gpe_sci_ctrl
   import gpe_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hp_evt,
   input  logic hp_en,
   input  logic sts_drop,
   input  logic en_drop,
   output logic line,
   output logic mark
);
   sci_act_e act;

   always_comb begin
      if (hp_evt && hp_en)       act = SCI_RAISE;
      else if (mark && en_drop)  act = SCI_DROP_ALL;
      else if (mark && sts_drop) act = SCI_DROP_LINE;
      else                       act = SCI_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line <= 1'b0;
         mark <= 1'b0;
      end else begin
         case (act)
            SCI_RAISE:     begin line <= 1'b1; mark <= 1'b1; end
            SCI_DROP_ALL:  begin line <= 1'b0; mark <= 1'b0; end
            SCI_DROP_LINE: line <= 1'b0;
            default:       ;
         endcase
      end
   end
endmodule

// File: rtl/gpe_event_block.sv
module gpe_event_block
   import gpe_pkg::*;
#(
   parameter int NUM_STS_BYTES = 2,
   parameter int HP_BYTE = 0,
   parameter int HP_BIT = 3
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 io_sel,
   input  logic                                 io_wr,
   input  logic [$clog2(2*NUM_STS_BYTES)-1:0]   io_addr,
   input  logic [7:0]                           io_wdata,
   output logic [7:0]                           io_rdata,
   input  logic [8*NUM_STS_BYTES-1:0]           evt_set,
   output logic                                 sci_line,
   output logic                                 sci_mark
);
   localparam int AW = $clog2(2*NUM_STS_BYTES);
   localparam int HP_FLAT = HP_BYTE * BYTE_W + HP_BIT;

   if (NUM_STS_BYTES < 1) begin : g_bad_n
      $error("NUM_STS_BYTES must be at least 1");
   end
   if (HP_BYTE >= NUM_STS_BYTES) begin : g_bad_byte
      $error("HP_BYTE outside the status bytes");
   end
   if (HP_BIT >= BYTE_W) begin : g_bad_bit
      $error("HP_BIT outside a byte");
   end

   logic [NUM_STS_BYTES-1:0] sts_we;
   logic [NUM_STS_BYTES-1:0] en_we;
   gbyte_t sts_q [NUM_STS_BYTES];
   gbyte_t en_q  [NUM_STS_BYTES];

   gpe_addr_dec #(.NUM_STS_BYTES(NUM_STS_BYTES), .AW(AW)) u_dec (
      .io_sel (io_sel),
      .io_wr  (io_wr),
      .io_addr(io_addr),
      .sts_we (sts_we),
      .en_we  (en_we)
   );

   for (genvar i = 0; i < NUM_STS_BYTES; i++) begin : g_byte
      gpe_sts_byte u_sts (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr_we  (sts_we[i]),
         .clr_mask(io_wdata),
         .set_mask(evt_set[i*BYTE_W +: BYTE_W]),
         .q       (sts_q[i])
      );

      always_ff @(posedge clk) begin
         if (!rst_n)       en_q[i] <= '0;
         else if (en_we[i]) en_q[i] <= io_wdata;
      end
   end

   always_comb begin
      io_rdata = '0;
      for (int i = 0; i < NUM_STS_BYTES; i++) begin
         if (io_addr == AW'(i))                 io_rdata = sts_q[i];
         if (io_addr == AW'(NUM_STS_BYTES + i)) io_rdata = en_q[i];
      end
   end

   logic sts_drop;
   logic en_drop;
   assign sts_drop = sts_we[HP_BYTE] & io_wdata[HP_BIT]
                   & sts_q[HP_BYTE][HP_BIT] & ~evt_set[HP_FLAT];
   assign en_drop  = en_we[HP_BYTE] & ~io_wdata[HP_BIT];

   gpe_sci_ctrl u_sci (
      .clk     (clk),
      .rst_n   (rst_n),
      .hp_evt  (evt_set[HP_FLAT]),
      .hp_en   (en_q[HP_BYTE][HP_BIT]),
      .sts_drop(sts_drop),
      .en_drop (en_drop),
      .line    (sci_line),
      .mark    (sci_mark)
   );
endmodule

// File: rtl/gpe_event_block_chk.sv
module gpe_event_block_chk (
   input logic clk,
   input logic rst_n,
   input logic hp_evt,
   input logic hp_en,
   input logic hp_sts,
   input logic hp_sts_wr,
   input logic hp_en_wr,
   input logic wbit,
   input logic sci_line,
   input logic sci_mark
);
   AST_LINE_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      sci_line |-> sci_mark); // R5
   AST_EVT_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n)
      hp_evt |=> hp_sts); // R4
   AST_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_evt && hp_en) |=> (sci_line && sci_mark)); // R10
   AST_EN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (sci_mark && !(hp_evt && hp_en) && hp_en_wr && !wbit) |=> (!sci_line && !sci_mark)); // R7
   AST_STS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (sci_mark && !hp_evt && hp_sts_wr && wbit && hp_sts) |=> (!sci_line && sci_mark)); // R6
   AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_sts_wr && wbit && !hp_evt) |=> !hp_sts); // R2
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(hp_evt && hp_en) && !hp_en_wr && !hp_sts_wr) |=> ($stable(sci_line) && $stable(sci_mark))); // R8
endmodule

bind gpe_event_block gpe_event_block_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hp_evt   (evt_set[HP_FLAT]),
   .hp_en    (en_q[HP_BYTE][HP_BIT]),
   .hp_sts   (sts_q[HP_BYTE][HP_BIT]),
   .hp_sts_wr(sts_we[HP_BYTE]),
   .hp_en_wr (en_we[HP_BYTE]),
   .wbit     (io_wdata[HP_BIT]),
   .sci_line (sci_line),
   .sci_mark (sci_mark)
);

// File: tb/gpe_event_block_test.sv
module gpe_event_block_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_sel = 1'b0;
   logic        io_wr = 1'b0;
   logic [1:0]  io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [15:0] evt_set = '0;
   logic        sci_line;
   logic        sci_mark;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpe_event_block uut (
      .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr),
      .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .evt_set(evt_set), .sci_line(sci_line), .sci_mark(sci_mark)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      io_sel = 1'b1; io_wr = 1'b1; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_sel = 1'b0; io_wr = 1'b0;
   endtask

   task automatic wr_evt(input logic [1:0] a, input logic [7:0] d, input logic [15:0] e);
      @(negedge clk);
      io_sel = 1'b1; io_wr = 1'b1; io_addr = a; io_wdata = d; evt_set = e;
      @(negedge clk);
      io_sel = 1'b0; io_wr = 1'b0; evt_set = '0;
   endtask

   task automatic pulse(input logic [15:0] e);
      @(negedge clk);
      evt_set = e;
      @(negedge clk);
      evt_set = '0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
      io_sel = 1'b1; io_wr = 1'b0; io_addr = a;
      #1;
      check(req, int'(io_rdata), exp);
      io_sel = 1'b0;
   endtask

   task automatic sci_chk(input int l, input int m, input string req);
      check({req, " line"}, int'(sci_line), l);
      check({req, " mark"}, int'(sci_mark), m);
   endtask

   task automatic t_reset();
      for (int a = 0; a < 4; a++) rd_chk(2'(a), 0, "R9 reset byte");
      sci_chk(0, 0, "R9 reset");
   endtask

   task automatic t_enable_rw();
      wr(2'd3, 8'hA5);
      wr(2'd2, 8'h51);
      rd_chk(2'd3, 8'hA5, "R3 enable byte1 readback");
      rd_chk(2'd2, 8'h51, "R1 enable byte0 at offset 2");
      rd_chk(2'd0, 0, "R1 status byte0 untouched");
      rd_chk(2'd1, 0, "R1 status byte1 untouched");
      wr(2'd3, 8'h0F);
      rd_chk(2'd3, 8'h0F, "R3 enable full replace");
      wr(2'd2, 8'h00);
      wr(2'd3, 8'h00);
   endtask

   task automatic t_w1c();
      pulse(16'h8124);
      rd_chk(2'd0, 8'h24, "R4 events set status byte0");
      rd_chk(2'd1, 8'h81, "R4 events set status byte1");
      sci_chk(0, 0, "R8 non-hotplug events");
      wr(2'd0, 8'h04);
      rd_chk(2'd0, 8'h20, "R2 partial clear");
      wr(2'd1, 8'h00);
      rd_chk(2'd1, 8'h81, "R2 zero write keeps bits");
      wr(2'd1, 8'hFF);
      rd_chk(2'd1, 8'h00, "R2 full clear");
      wr(2'd0, 8'hFF);
      rd_chk(2'd0, 8'h00, "R2 full clear byte0");
   endtask

   task automatic t_hp_disabled();
      pulse(16'h0008);
      rd_chk(2'd0, 8'h08, "R5 hotplug status with enable off");
      sci_chk(0, 0, "R5 no SCI when disabled");
      wr(2'd0, 8'h08);
   endtask

   task automatic t_sts_path();
      wr(2'd2, 8'h08);
      pulse(16'h0008);
      sci_chk(1, 1, "R5 raise");
      wr(2'd0, 8'h08);
      sci_chk(0, 1, "R6 status clear keeps mark");
      rd_chk(2'd0, 0, "R6 status bit cleared");
      wr(2'd2, 8'h08);
      sci_chk(0, 1, "R8 enable write bit3 set");
      wr(2'd2, 8'h00);
      sci_chk(0, 0, "R7 enable clear drops mark");
   endtask

   task automatic t_en_path();
      wr(2'd2, 8'h08);
      pulse(16'h0008);
      sci_chk(1, 1, "R5 raise again");
      wr(2'd2, 8'h01);
      sci_chk(0, 0, "R7 enable path drops both");
      rd_chk(2'd0, 8'h08, "R7 status unchanged");
      wr(2'd0, 8'h08);
      sci_chk(0, 0, "R6 no change when mark clear");
   endtask

   task automatic t_no_effect();
      wr(2'd2, 8'h08);
      pulse(16'h0008);
      sci_chk(1, 1, "R5 raise for neighbour test");
      wr(2'd3, 8'h00);
      sci_chk(1, 1, "R8 enable byte1 write");
      wr(2'd0, 8'h04);
      sci_chk(1, 1, "R8 status other bit clear");
      wr(2'd1, 8'hFF);
      sci_chk(1, 1, "R8 status byte1 clear");
   endtask

   task automatic t_collide();
      wr_evt(2'd0, 8'h08, 16'h0008);
      rd_chk(2'd0, 8'h08, "R4 set wins over clear");
      sci_chk(1, 1, "R10 event beats status clear");
      wr_evt(2'd2, 8'h00, 16'h0008);
      sci_chk(1, 1, "R10 event beats enable clear");
      rd_chk(2'd2, 8'h00, "R3 enable written in collision");
      wr(2'd2, 8'h00);
      sci_chk(0, 0, "R7 drop after collision");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable_rw();
      t_w1c();
      t_hp_disabled();
      t_sts_path();
      t_en_path();
      t_no_effect();
      t_collide();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule